// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns one bus request from an 8-bit processor core into the pin-level timing of a single external bus cycle on a 16-bit address space. The low address byte and the data byte share one set of lines. The core presents a request on the port side: a cycle kind, an address, write data and an optional stretch flag. The sequencer then steps through numbered T-states, one per clock.

In T1 the sequencer puts the full address out and raises the address strobe, so that an external latch can hold the low byte. In the later T-states the shared lines carry data. For reads they are released while the active-low read strobe samples memory. For writes they are driven while the active-low write strobe is low.

A three-bit status (I/O-versus-memory select plus two status bits) names the kind of cycle for the whole of its length. That status is how an opcode fetch is told apart from a plain memory read. The core sees the byte read and a one-cycle completion pulse, and may issue its next request once the sequencer reports idle again.

Top module: `mbs_sequencer`

## Requirements
- R1: Out of reset and whenever idle: `req_ready`=1, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0, `io_m`=0, `s1`=0, `s0`=0 and `addr_hi`=0.
- R2: A request is accepted on a rising edge where `req_ready`=1 and `req_valid`=1, and the next cycle is T1. In T1: `ale`=1, `ad_oe`=1, `ad_out`=address bits 7..0. `addr_hi` carries address bits 15..8 from T1 through the last T-state. `ale` is 0 in every other T-state.
- R3: The `req_kind` codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. The matching {`io_m`,`s1`,`s0`} is 011, 010, 001, 110, 101, held constant from T1 through the last T-state.
- R4: An opcode fetch lasts 4 T-states. `rd_n` is 0 in T2 and T3 only. T4 has every strobe inactive and `ad_oe`=0. `done`=1 in T4, with `rdata` equal to the byte on `ad_in` during T3.
- R5: An opcode fetch with `req_long`=1 lasts 6 T-states. T5 and T6 are like T4, and `done`=1 only in T6.
- R6: A memory read or I/O read lasts 3 T-states. `rd_n`=0 and `ad_oe`=0 in T2 and T3. `done`=1 in T3, with `rdata` equal to `ad_in` during T3.
- R7: A memory write or I/O write lasts 3 T-states. In T2 and T3, `ad_oe`=1, `ad_out`=write data and `wr_n`=0. `done`=1 in T3.
- R8: While a cycle runs, `req_ready`=0 and any request is ignored. `req_long` has no effect on kinds other than opcode fetch.
- R9: A request with a `req_kind` code of 5, 6 or 7 is not accepted: the block stays idle.
- R10: Outside a read's T3, `rdata` holds the last byte read, including during and after write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle kind code |
| req_long | input | 1 | Stretch an opcode fetch to six T-states |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Idle, a request can be accepted |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Shared-lines drive value |
| ad_oe | output | 1 | Shared-lines drive enable |
| ad_in | input | 8 | Shared-lines sampled value |
| ale | output | 1 | Address strobe, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for I/O cycle, 0 for memory cycle |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rdata | output | 8 | Byte read |
| done | output | 1 | Pulse in the last T-state |

## Verification
T1 appears one clock after the accepting edge. Each following T-state is one more clock. `done` coincides with T3, T4 or T6 depending on kind. A read's byte is visible on `rdata` within T3 itself and is held from the edge that ends T3. The bench drives requests on falling edges and walks T-states one falling edge at a time. It sets `ad_in` for the T-state and then compares the pins before the next rising edge. A decoy byte on `ad_in` outside T3 shows that sampling takes place in that T-state only.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        KIND_FETCH = 3'd0,
        KIND_MRD   = 3'd1,
        KIND_MWR   = 3'd2,
        KIND_IORD  = 3'd3,
        KIND_IOWR  = 3'd4
    } bus_kind_e;

    // Per-cycle pin attributes derived from the kind code
    typedef struct packed {
        logic legal;
        logic io_m;
        logic s1;
        logic s0;
        logic is_rd;
        logic is_wr;
    } kind_attr_t;

endpackage

// File: rtl/mbs_kind_decode.sv
module mbs_kind_decode
    import mbs_pkg::*;
#(
    parameter int SHORT_T = 3,
    parameter int FETCH_T = 4,
    parameter int LONG_T  = 6,
    parameter int TW      = 3
) (
    input  logic [KIND_W-1:0] kind,
    input  logic              long_req,
    output kind_attr_t        attr,
    output logic [TW-1:0]     last_t
);

    always_comb begin
        attr   = '0;
        last_t = TW'(SHORT_T);
        case (kind)
            KIND_FETCH: begin
                attr   = '{legal: 1'b1, io_m: 1'b0, s1: 1'b1, s0: 1'b1, is_rd: 1'b1, is_wr: 1'b0};
                last_t = long_req ? TW'(LONG_T) : TW'(FETCH_T);
            end
            KIND_MRD:  attr = '{legal: 1'b1, io_m: 1'b0, s1: 1'b1, s0: 1'b0, is_rd: 1'b1, is_wr: 1'b0};
            KIND_MWR:  attr = '{legal: 1'b1, io_m: 1'b0, s1: 1'b0, s0: 1'b1, is_rd: 1'b0, is_wr: 1'b1};
            KIND_IORD: attr = '{legal: 1'b1, io_m: 1'b1, s1: 1'b1, s0: 1'b0, is_rd: 1'b1, is_wr: 1'b0};
            KIND_IOWR: attr = '{legal: 1'b1, io_m: 1'b1, s1: 1'b0, s0: 1'b1, is_rd: 1'b0, is_wr: 1'b1};
            default:   attr = '0;
        endcase
    end

endmodule

// File: rtl/mbs_tstate_ctrl.sv
module mbs_tstate_ctrl
    import mbs_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int TW       = 3,
    parameter int SAMPLE_T = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  kind_attr_t        attr_in,
    input  logic [TW-1:0]     last_in,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic              busy,
    output logic [TW-1:0]     tcnt,
    output logic [TW-1:0]     last_t,
    output logic              st_io_m,
    output logic              st_s1,
    output logic              st_s0,
    output logic              st_rd,
    output logic              st_wr,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    typedef struct packed {
        logic              busy;
        logic [TW-1:0]     tcnt;
        logic [TW-1:0]     last;
        logic              io_m;
        logic              s1;
        logic              s0;
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (req_valid && attr_in.legal) begin
                st_d.busy  = 1'b1;
                st_d.tcnt  = TW'(1);
                st_d.last  = last_in;
                st_d.io_m  = attr_in.io_m;
                st_d.s1    = attr_in.s1;
                st_d.s0    = attr_in.s0;
                st_d.rd    = attr_in.is_rd;
                st_d.wr    = attr_in.is_wr;
                st_d.addr  = req_addr;
                st_d.wdata = req_wdata;
            end
        end else begin
            if (st_q.rd && st_q.tcnt == TW'(SAMPLE_T)) begin
                st_d.rdata = ad_in;
            end
            if (st_q.tcnt == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.tcnt = '0;
                st_d.io_m = 1'b0;
                st_d.s1   = 1'b0;
                st_d.s0   = 1'b0;
                st_d.rd   = 1'b0;
                st_d.wr   = 1'b0;
            end else begin
                st_d.tcnt = st_q.tcnt + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign tcnt    = st_q.tcnt;
    assign last_t  = st_q.last;
    assign st_io_m = st_q.io_m;
    assign st_s1   = st_q.s1;
    assign st_s0   = st_q.s0;
    assign st_rd   = st_q.rd;
    assign st_wr   = st_q.wr;
    assign addr_q  = st_q.addr;
    assign wdata_q = st_q.wdata;
    assign rdata_q = st_q.rdata;

endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int TW          = 3,
    parameter int STROBE_FIRST = 2,
    parameter int STROBE_LAST  = 3
) (
    input  logic              busy,
    input  logic [TW-1:0]     tcnt,
    input  logic [TW-1:0]     last_t,
    input  logic              st_io_m,
    input  logic              st_s1,
    input  logic              st_s0,
    input  logic              st_rd,
    input  logic              st_wr,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DATA_W-1:0] rdata_q,
    input  logic [DATA_W-1:0] ad_in,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m,
    output logic              s1,
    output logic              s0,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    logic in_t1;
    logic in_strobe;
    logic in_sample;

    always_comb begin
        in_t1     = busy && (tcnt == TW'(1));
        in_strobe = busy && (tcnt >= TW'(STROBE_FIRST)) && (tcnt <= TW'(STROBE_LAST));
        in_sample = busy && st_rd && (tcnt == TW'(STROBE_LAST));

        ale     = in_t1;
        rd_n    = !(in_strobe && st_rd);
        wr_n    = !(in_strobe && st_wr);
        ad_oe   = in_t1 || (in_strobe && st_wr);
        if (in_t1) begin
            ad_out = addr_q[DATA_W-1:0];
        end else if (in_strobe && st_wr) begin
            ad_out = wdata_q;
        end else begin
            ad_out = '0;
        end
        addr_hi = busy ? addr_q[ADDR_W-1:DATA_W] : '0;
        io_m    = busy && st_io_m;
        s1      = busy && st_s1;
        s0      = busy && st_s0;
        done    = busy && (tcnt == last_t);
        rdata   = in_sample ? ad_in : rdata_q;
    end

endmodule

// File: rtl/mbs_sequencer.sv
module mbs_sequencer
    import mbs_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int SHORT_T = 3,
    parameter int FETCH_T = 4,
    parameter int LONG_T  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [KIND_W-1:0]        req_kind,
    input  logic                     req_long,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     io_m,
    output logic                     s1,
    output logic                     s0,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done
);

    localparam int TW       = $clog2(LONG_T + 1);
    localparam int STRB_LO  = 2;
    localparam int STRB_HI  = SHORT_T;

    kind_attr_t        attr;
    logic [TW-1:0]     last_in;
    logic              busy;
    logic [TW-1:0]     tcnt;
    logic [TW-1:0]     last_t;
    logic              st_io_m, st_s1, st_s0, st_rd, st_wr;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    mbs_kind_decode #(
        .SHORT_T (SHORT_T),
        .FETCH_T (FETCH_T),
        .LONG_T  (LONG_T),
        .TW      (TW)
    ) u_dec (
        .kind     (req_kind),
        .long_req (req_long),
        .attr     (attr),
        .last_t   (last_in)
    );

    mbs_tstate_ctrl #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .TW       (TW),
        .SAMPLE_T (STRB_HI)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .attr_in   (attr),
        .last_in   (last_in),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ad_in     (ad_in),
        .busy      (busy),
        .tcnt      (tcnt),
        .last_t    (last_t),
        .st_io_m   (st_io_m),
        .st_s1     (st_s1),
        .st_s0     (st_s0),
        .st_rd     (st_rd),
        .st_wr     (st_wr),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata_q   (rdata_q)
    );

    mbs_pin_drive #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .TW           (TW),
        .STROBE_FIRST (STRB_LO),
        .STROBE_LAST  (STRB_HI)
    ) u_pins (
        .busy    (busy),
        .tcnt    (tcnt),
        .last_t  (last_t),
        .st_io_m (st_io_m),
        .st_s1   (st_s1),
        .st_s0   (st_s0),
        .st_rd   (st_rd),
        .st_wr   (st_wr),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .rdata_q (rdata_q),
        .ad_in   (ad_in),
        .addr_hi (addr_hi),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .io_m    (io_m),
        .s1      (s1),
        .s0      (s0),
        .rdata   (rdata),
        .done    (done)
    );

    assign req_ready = !busy;

endmodule

// File: rtl/mbs_sequencer_chk.sv
module mbs_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_kind,
    input logic       req_ready,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic       ad_oe,
    input logic       io_m,
    input logic       s1,
    input logic       s0,
    input logic       done
);

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R3

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale); // R2

    AST_ACCEPT_GIVES_T1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && req_kind <= 3'd4) |=> (ale && !req_ready)); // R2

    AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_kind > 3'd4) |=> req_ready); // R9

    AST_READ_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe); // R6

    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done)); // R8

    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && !req_ready) |-> $stable({io_m, s1, s0})); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rd_n && wr_n && !ale && !ad_oe && !done)); // R1

endmodule

bind mbs_sequencer mbs_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_ready (req_ready),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ad_oe     (ad_oe),
    .io_m      (io_m),
    .s1        (s1),
    .s0        (s0),
    .done      (done)
);

// File: tb/mbs_sequencer_test.sv
module mbs_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic        req_long = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  addr_hi;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in = '0;
    logic        ale, rd_n, wr_n, io_m, s1, s0, done;
    logic [7:0]  rdata;

    int tests = 0;
    int fails = 0;
    logic [7:0] last_read = 8'h00;

    always #2 clk = ~clk;

    mbs_sequencer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_long(req_long), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
        .s1(s1), .s0(s0), .rdata(rdata), .done(done)
    );

    // {kind[3], long[1], addr[16], wdata[8], rbyte[8]}
    localparam int NV = 8;
    localparam logic [35:0] VEC [NV] = '{
        {3'd0, 1'b0, 16'h2005, 8'h00, 8'h4F},
        {3'd1, 1'b0, 16'h2001, 8'h00, 8'h32},
        {3'd2, 1'b0, 16'h2065, 8'hA5, 8'h00},
        {3'd3, 1'b0, 16'h00F3, 8'h00, 8'hC3},
        {3'd4, 1'b0, 16'h0081, 8'h5A, 8'h00},
        {3'd0, 1'b1, 16'hFFFF, 8'h00, 8'h80},
        {3'd1, 1'b1, 16'h0000, 8'h00, 8'h01},
        {3'd0, 1'b0, 16'h1234, 8'h00, 8'hFF}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, {req_ready, ale, rd_n, wr_n, ad_oe, done, io_m, s1, s0, addr_hi},
                   {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 8'h00});
    endtask

    task automatic run_cycle(input logic [2:0] kind, input logic lng, input logic [15:0] addr,
                             input logic [7:0] wd, input logic [7:0] rb, input logic poke);
        int n;
        logic rd, wr;
        logic [2:0] stat;
        string kreq;
        rd = (kind == 3'd0) || (kind == 3'd1) || (kind == 3'd3);
        wr = (kind == 3'd2) || (kind == 3'd4);
        n  = (kind == 3'd0) ? (lng ? 6 : 4) : 3;
        case (kind)
            3'd0: stat = 3'b011;
            3'd1: stat = 3'b010;
            3'd2: stat = 3'b001;
            3'd3: stat = 3'b110;
            default: stat = 3'b101;
        endcase
        kreq = (kind == 3'd0) ? (lng ? "R5" : "R4") : (rd ? "R6" : "R7");
        @(negedge clk);
        check("R2 ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_kind = kind; req_long = lng; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 1; t <= n; t++) begin
            ad_in = (t == 3) ? rb : ~rb;
            if (poke && t >= 2 && t < n) begin
                req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'hBEEF;
            end else begin
                req_valid = 1'b0;
            end
            #1;
            if (t == 1)
                check("R2 T1 address phase", {ale, ad_oe, ad_out, addr_hi}, {2'b11, addr[7:0], addr[15:8]});
            else
                check("R2 later T-state", {ale, addr_hi}, {1'b0, addr[15:8]});
            check("R3 status", {io_m, s1, s0, req_ready}, {stat, 1'b0});
            if (t >= 2) begin
                check(kreq, {rd_n, wr_n, ad_oe, (ad_oe ? ad_out : 8'h00), done},
                      {!(rd && t <= 3), !(wr && t <= 3), (wr && t <= 3),
                       ((wr && t <= 3) ? wd : 8'h00), (t == n)});
            end
            if (t == n && rd) begin
                check({kreq, " read byte"}, {24'd0, rdata}, {24'd0, rb});
                last_read = rb;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        ad_in = 8'h00;
        #1;
        check_idle(poke ? "R8 busy request ignored" : "R1 idle after cycle");
        check("R10 rdata held", {24'd0, rdata}, {24'd0, last_read});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1;
        check_idle("R1 during reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
        check("R1 rdata reset", {24'd0, rdata}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_cycle(VEC[i][35:33], VEC[i][32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0], 1'b0);
        end

        // R8: requests during a running fetch are dropped
        run_cycle(3'd0, 1'b0, 16'h4321, 8'h00, 8'h77, 1'b1);
        @(negedge clk);
        check("R8 no start after busy request", {31'd0, ale}, 32'd0);

        // R9: illegal kind codes never start a cycle
        for (int k = 5; k < 8; k++) begin
            @(negedge clk);
            req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'h5555;
            @(negedge clk);
            #1;
            check("R9 illegal kind ignored", {req_ready, ale, rd_n, wr_n, ad_oe}, {5'b10110});
            req_valid = 1'b0;
        end

        // R10: write after read keeps the read byte
        run_cycle(3'd3, 1'b0, 16'h0042, 8'h00, 8'h9C, 1'b0);
        run_cycle(3'd2, 1'b1, 16'h3000, 8'h3C, 8'h00, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule